// File: doc/BRIEF.md
# Shortcut-Aware Mesh Route Computation

This unit computes the output port for one router of a square SIDE-by-SIDE mesh that is augmented with eight fixed long-range shortcut links joining its four corner regions. From the router's own coordinates, the destination coordinates of an incoming head flit and a flag saying whether this router owns a shortcut port, it picks one of six output ports. The ports are local, north, south, east, west and shortcut.

Short trips use plain dimension-order (row first, then column) routing. Long trips take the shortcut port when this router has one. When this router has no shortcut port, a long trip is steered one XY hop toward the closest router that owns a shortcut. The chosen port is latched when a head flit arrives and is held for the whole packet. It is released when the tail flit is seen.

The control is a two-state machine. IDLE means no packet is in flight and the port output is zero. BUSY means a route is latched and driven. The transitions are:
- IDLE to BUSY on a head strobe, which loads the route.
- BUSY to BUSY on a head strobe together with a tail strobe, which loads the new route for back-to-back packets.
- BUSY to IDLE on a tail strobe alone, which clears the port.

Every other input combination leaves the state and the port unchanged.

Top module: `rc_route_unit`

## Requirements
- R1: Coordinates are X = row index and Y = column index, each $clog2(SIDE) bits wide. The one-hot `port_sel` bit map is: bit0 local, bit1 north, bit2 south, bit3 east, bit4 west, bit5 shortcut.
- R2: When the destination equals the current node, the local port (bit0) is chosen.
- R3: Plain XY steps the row first: a destination row greater than the current row gives south, and a smaller one gives north. With the rows equal, a greater column gives east and a smaller one gives west.
- R4: With D = 2*(SIDE-1), plain XY toward the destination is used, whatever the shortcut flag, when the rows are equal, or the columns are equal, or |dX|+|dY| <= D-1. The case equal to D-1 is included.
- R5: When |dX|+|dY| > D-1, the rows differ, the columns differ and `has_shortcut` is 1, the shortcut port (bit5) is chosen.
- R6: Under the same far condition with `has_shortcut` 0, the unit takes one XY step toward the shortcut owner nearest by Manhattan distance. The owners, in tie-break order, are (0,1), (1,0), (0,S-2), (1,S-1), (S-2,0), (S-1,1), (S-1,S-2), (S-2,S-1), where S = SIDE. If that owner is the current node itself, plain XY toward the destination is used.
- R7: In IDLE, a head strobe latches the route, and the route is visible on `port_sel` after that clock edge.
- R8: In BUSY without a tail strobe, `port_sel` holds its value. A head strobe alone and any change of the coordinates or the flag are ignored.
- R9: In BUSY, a tail strobe alone clears `port_sel` to zero after the edge. A tail strobe in IDLE is ignored.
- R10: In BUSY, a head strobe together with a tail strobe replaces the route with the one for the current inputs after the edge.
- R11: Synchronous active-high reset clears `port_sel` to zero. `port_sel` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_x | input | CW | Row index of this router |
| cur_y | input | CW | Column index of this router |
| dst_x | input | CW | Destination row from the head flit |
| dst_y | input | CW | Destination column from the head flit |
| has_shortcut | input | 1 | This router owns a shortcut port |
| head_vld | input | 1 | Head flit strobe |
| tail_vld | input | 1 | Tail flit strobe |
| port_sel | output | 6 | Latched one-hot output port |

## Verification
The two functions that can meet in one cycle are the release of a packet's route on its tail strobe and the latching of the next packet's route on a head strobe. The bench provokes this on purpose. Its exhaustive sweeps over every source, destination and shortcut-flag combination, in both a 4x4 and a 5x5 instance, run with the head and tail strobes raised together on every cycle. Each cycle must therefore show the route of the newest packet, and never zero or the stale port. Each result is judged against a reference model written from the requirements. Directed cases then separate the two strobes to confirm the hold, the clear and the ignore rules.

// File: rtl/rc_pkg.sv
package rc_pkg;

    typedef enum logic [2:0] {
        P_LOCAL = 3'd0,
        P_NORTH = 3'd1,
        P_SOUTH = 3'd2,
        P_EAST  = 3'd3,
        P_WEST  = 3'd4,
        P_SHORT = 3'd5
    } port_e;

    localparam int NPORT  = 6;
    localparam int NOWNER = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } rc_state_e;

    // Shortcut owner coordinates; order is the tie-break priority.
    function automatic int owner_row(input int side, input int k);
        case (k)
            0: return 0;
            1: return 1;
            2: return 0;
            3: return 1;
            4: return side - 2;
            5: return side - 1;
            6: return side - 1;
            default: return side - 2;
        endcase
    endfunction

    function automatic int owner_col(input int side, input int k);
        case (k)
            0: return 1;
            1: return 0;
            2: return side - 2;
            3: return side - 1;
            4: return 0;
            5: return 1;
            6: return side - 2;
            default: return side - 1;
        endcase
    endfunction

    // One dimension-order step: row first, then column.
    function automatic port_e xy_step(input logic same_row, input logic go_south,
                                      input logic same_col, input logic go_east);
        if (!same_row)      return go_south ? P_SOUTH : P_NORTH;
        else if (!same_col) return go_east ? P_EAST : P_WEST;
        else                return P_LOCAL;
    endfunction

endpackage

// File: rtl/rc_offset.sv
module rc_offset #(
    parameter int CW = 2
) (
    input  logic [CW-1:0] from_x,
    input  logic [CW-1:0] from_y,
    input  logic [CW-1:0] to_x,
    input  logic [CW-1:0] to_y,
    output logic          same_row,
    output logic          same_col,
    output logic          go_south,
    output logic          go_east,
    output logic [CW:0]   dist_sum
);
    logic [CW-1:0] mag_x;
    logic [CW-1:0] mag_y;

    always_comb begin
        go_south = to_x > from_x;
        go_east  = to_y > from_y;
        same_row = to_x == from_x;
        same_col = to_y == from_y;
        mag_x    = go_south ? (to_x - from_x) : (from_x - to_x);
        mag_y    = go_east  ? (to_y - from_y) : (from_y - to_y);
        dist_sum = {1'b0, mag_x} + {1'b0, mag_y};
    end
endmodule

// File: rtl/rc_target.sv
module rc_target
    import rc_pkg::*;
#(
    parameter int SIDE = 4,
    parameter int CW   = 2
) (
    input  logic [CW-1:0] cur_x,
    input  logic [CW-1:0] cur_y,
    output logic [CW-1:0] tgt_x,
    output logic [CW-1:0] tgt_y,
    output logic          tgt_self
);
    logic [CW-1:0] cand_x [NOWNER];
    logic [CW-1:0] cand_y [NOWNER];
    logic [CW:0]   cand_d [NOWNER];

    for (genvar k = 0; k < NOWNER; k++) begin : g_cand
        localparam int ROW = owner_row(SIDE, k);
        localparam int COL = owner_col(SIDE, k);
        logic same_row_k;
        logic same_col_k;
        logic south_k;
        logic east_k;
        assign cand_x[k] = CW'(ROW);
        assign cand_y[k] = CW'(COL);
        rc_offset #(.CW(CW)) u_dist (
            .from_x   (cur_x),
            .from_y   (cur_y),
            .to_x     (cand_x[k]),
            .to_y     (cand_y[k]),
            .same_row (same_row_k),
            .same_col (same_col_k),
            .go_south (south_k),
            .go_east  (east_k),
            .dist_sum (cand_d[k])
        );
    end

    // Strict less-than keeps the lowest index on a tie.
    always_comb begin
        logic [CW:0] best_d;
        best_d = cand_d[0];
        tgt_x  = cand_x[0];
        tgt_y  = cand_y[0];
        for (int k = 1; k < NOWNER; k++) begin
            if (cand_d[k] < best_d) begin
                best_d = cand_d[k];
                tgt_x  = cand_x[k];
                tgt_y  = cand_y[k];
            end
        end
        tgt_self = best_d == '0;
    end
endmodule

// File: rtl/rc_decide.sv
module rc_decide
    import rc_pkg::*;
#(
    parameter int SIDE = 4,
    parameter int CW   = 2
) (
    input  logic [CW-1:0] cur_x,
    input  logic [CW-1:0] cur_y,
    input  logic [CW-1:0] dst_x,
    input  logic [CW-1:0] dst_y,
    input  logic          has_shortcut,
    output port_e         route
);
    localparam int DIAM  = 2 * (SIDE - 1);
    localparam int LIMIT = DIAM - 1;

    logic          d_row, d_col, d_south, d_east;
    logic [CW:0]   d_sum;
    logic [CW-1:0] tgt_x, tgt_y;
    logic          tgt_self;
    logic          t_row, t_col, t_south, t_east;
    logic [CW:0]   t_sum;
    logic          far;

    rc_offset #(.CW(CW)) u_to_dst (
        .from_x   (cur_x),
        .from_y   (cur_y),
        .to_x     (dst_x),
        .to_y     (dst_y),
        .same_row (d_row),
        .same_col (d_col),
        .go_south (d_south),
        .go_east  (d_east),
        .dist_sum (d_sum)
    );

    rc_target #(.SIDE(SIDE), .CW(CW)) u_target (
        .cur_x    (cur_x),
        .cur_y    (cur_y),
        .tgt_x    (tgt_x),
        .tgt_y    (tgt_y),
        .tgt_self (tgt_self)
    );

    rc_offset #(.CW(CW)) u_to_tgt (
        .from_x   (cur_x),
        .from_y   (cur_y),
        .to_x     (tgt_x),
        .to_y     (tgt_y),
        .same_row (t_row),
        .same_col (t_col),
        .go_south (t_south),
        .go_east  (t_east),
        .dist_sum (t_sum)
    );

    assign far = d_sum > (CW+1)'(LIMIT);

    always_comb begin
        if (d_row && d_col)
            route = P_LOCAL;
        else if (!far || d_row || d_col)
            route = xy_step(d_row, d_south, d_col, d_east);
        else if (has_shortcut)
            route = P_SHORT;
        else if (tgt_self || t_sum == '0)
            route = xy_step(d_row, d_south, d_col, d_east);
        else
            route = xy_step(t_row, t_south, t_col, t_east);
    end
endmodule

// File: rtl/rc_route_unit.sv
module rc_route_unit
    import rc_pkg::*;
#(
    parameter int SIDE = 4,
    parameter int CW   = $clog2(SIDE)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cur_x,
    input  logic [CW-1:0] cur_y,
    input  logic [CW-1:0] dst_x,
    input  logic [CW-1:0] dst_y,
    input  logic          has_shortcut,
    input  logic          head_vld,
    input  logic          tail_vld,
    output logic [5:0]    port_sel
);
    rc_state_e        state_q, state_d;
    port_e            route;
    logic [NPORT-1:0] route_oh;
    logic [NPORT-1:0] port_q;

    rc_decide #(.SIDE(SIDE), .CW(CW)) u_decide (
        .cur_x        (cur_x),
        .cur_y        (cur_y),
        .dst_x        (dst_x),
        .dst_y        (dst_y),
        .has_shortcut (has_shortcut),
        .route        (route)
    );

    assign route_oh = NPORT'(1) << route;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (head_vld) state_d = ST_BUSY;
            ST_BUSY: if (tail_vld && !head_vld) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            port_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (head_vld) port_q <= route_oh;
                ST_BUSY: if (tail_vld) port_q <= head_vld ? route_oh : '0;
                default: port_q <= '0;
            endcase
        end
    end

    assign port_sel = port_q;
endmodule

// File: rtl/rc_route_chk.sv
module rc_route_chk #(
    parameter int SIDE = 4,
    parameter int CW   = 2
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] cur_x,
    input logic [CW-1:0] cur_y,
    input logic [CW-1:0] dst_x,
    input logic [CW-1:0] dst_y,
    input logic          has_shortcut,
    input logic          head_vld,
    input logic          tail_vld,
    input logic [5:0]    port_sel
);
    logic idle_now;
    assign idle_now = port_sel == '0;

    assert_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(port_sel));

    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> port_sel == '0);

    assert_local_R2: assert property (@(posedge clk) disable iff (rst)
        (head_vld && (idle_now || tail_vld) && cur_x == dst_x && cur_y == dst_y)
        |=> port_sel == 6'b000001);

    assert_no_short_R5: assert property (@(posedge clk) disable iff (rst)
        (head_vld && (idle_now || tail_vld) && !has_shortcut) |=> !port_sel[5]);

    assert_head_loads_R7: assert property (@(posedge clk) disable iff (rst)
        (idle_now && head_vld) |=> port_sel != '0);

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!idle_now && !tail_vld) |=> $stable(port_sel));

    assert_tail_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (!idle_now && tail_vld && !head_vld) |=> port_sel == '0);

    assert_idle_stays_R9: assert property (@(posedge clk) disable iff (rst)
        (idle_now && !head_vld) |=> port_sel == '0);
endmodule

bind rc_route_unit rc_route_chk #(.SIDE(SIDE), .CW(CW)) u_chk (.*);

// File: tb/tb_rc_route_unit.sv
module tb_rc_route_unit;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] a_cx, a_cy, a_dx, a_dy;
    logic [2:0] b_cx, b_cy, b_dx, b_dy;
    logic       a_sc, b_sc, a_h, a_t, b_h, b_t;
    logic [5:0] a_port, b_port;
    int         total = 0;
    int         bad = 0;
    bit         finished = 0;

    always #(PERIOD/2) clk = ~clk;

    rc_route_unit #(.SIDE(4)) dut (
        .clk(clk), .rst(rst), .cur_x(a_cx), .cur_y(a_cy), .dst_x(a_dx), .dst_y(a_dy),
        .has_shortcut(a_sc), .head_vld(a_h), .tail_vld(a_t), .port_sel(a_port));

    rc_route_unit #(.SIDE(5)) dut5 (
        .clk(clk), .rst(rst), .cur_x(b_cx), .cur_y(b_cy), .dst_x(b_dx), .dst_y(b_dy),
        .has_shortcut(b_sc), .head_vld(b_h), .tail_vld(b_t), .port_sel(b_port));

    typedef struct packed {
        logic [2:0] cx, cy, dx, dy;
        logic       sc;
        logic [5:0] exp;
    } vec_t;

    // Directed vectors for the 4x4 instance (bit0 L, 1 N, 2 S, 3 E, 4 W, 5 shortcut).
    localparam vec_t VECS [8] = '{
        '{3'd1, 3'd2, 3'd1, 3'd2, 1'b0, 6'b000001},
        '{3'd0, 3'd0, 3'd3, 3'd3, 1'b0, 6'b001000},
        '{3'd0, 3'd0, 3'd3, 3'd3, 1'b1, 6'b100000},
        '{3'd3, 3'd3, 3'd0, 3'd0, 1'b0, 6'b010000},
        '{3'd0, 3'd3, 3'd3, 3'd0, 1'b0, 6'b010000},
        '{3'd3, 3'd0, 3'd0, 3'd3, 1'b0, 6'b000010},
        '{3'd0, 3'd0, 3'd3, 3'd2, 1'b1, 6'b000100},
        '{3'd2, 3'd1, 3'd2, 3'd3, 1'b1, 6'b001000}
    };

    function automatic int xy_idx(int cx, int cy, int dx, int dy);
        if (dx > cx) return 2;
        if (dx < cx) return 1;
        if (dy > cy) return 3;
        if (dy < cy) return 4;
        return 0;
    endfunction

    function automatic int own_r(int s, int k);
        int t [8] = '{0, 1, 0, 1, s-2, s-1, s-1, s-2};
        return t[k];
    endfunction

    function automatic int own_c(int s, int k);
        int t [8] = '{1, 0, s-2, s-1, 0, 1, s-2, s-1};
        return t[k];
    endfunction

    function automatic int iabs(int v);
        return v < 0 ? -v : v;
    endfunction

    function automatic logic [5:0] ref_port(int s, int cx, int cy, int dx, int dy, bit sc);
        int sum, best, br, bc;
        sum = iabs(dx - cx) + iabs(dy - cy);
        if (cx == dx || cy == dy || sum <= 2*(s-1) - 1)
            return 6'(1) << xy_idx(cx, cy, dx, dy);
        if (sc) return 6'b100000;
        best = 1000; br = 0; bc = 0;
        for (int k = 0; k < 8; k++) begin
            int d;
            d = iabs(own_r(s, k) - cx) + iabs(own_c(s, k) - cy);
            if (d < best) begin best = d; br = own_r(s, k); bc = own_c(s, k); end
        end
        if (best == 0) return 6'(1) << xy_idx(cx, cy, dx, dy);
        return 6'(1) << xy_idx(cx, cy, br, bc);
    endfunction

    task automatic chk(string tag, logic [5:0] got, logic [5:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        a_cx = '0; a_cy = '0; a_dx = '0; a_dy = '0; a_sc = 0; a_h = 0; a_t = 0;
        b_cx = '0; b_cy = '0; b_dx = '0; b_dy = '0; b_sc = 0; b_h = 0; b_t = 0;
        @(negedge clk);
        tick();
        tick();
        chk("R11 reset 4x4", a_port, 6'b0);
        chk("R11 reset 5x5", b_port, 6'b0);
        rst = 0;

        // R7: a head strobe in IDLE latches the route.
        a_cx = 2'd1; a_cy = 2'd1; a_dx = 2'd1; a_dy = 2'd0; a_h = 1;
        tick();
        chk("R7 head from idle (west)", a_port, 6'b010000);

        // R10 table walk: head and tail together on every cycle.
        a_t = 1;
        foreach (VECS[i]) begin
            a_cx = VECS[i].cx[1:0]; a_cy = VECS[i].cy[1:0];
            a_dx = VECS[i].dx[1:0]; a_dy = VECS[i].dy[1:0];
            a_sc = VECS[i].sc;
            tick();
            chk($sformatf("R10 R2 R4 R5 R6 vector %0d", i), a_port, VECS[i].exp);
        end

        // R8: no tail; head alone and input changes are ignored.
        a_t = 0; a_h = 1; a_cx = 2'd0; a_cy = 2'd0; a_dx = 2'd0; a_dy = 2'd0;
        tick();
        chk("R8 hold under head alone", a_port, 6'b001000);
        a_h = 0; a_sc = 0;
        tick();
        chk("R8 hold with no strobe", a_port, 6'b001000);

        // R9: tail alone clears; tail in IDLE ignored.
        a_t = 1;
        tick();
        chk("R9 tail clears", a_port, 6'b0);
        a_cx = 2'd3; a_dx = 2'd0;
        tick();
        chk("R9 tail in idle ignored", a_port, 6'b0);
        a_t = 0;

        // Exhaustive sweeps with back-to-back packets (R1 R3 R4 R5 R6 R10).
        a_h = 1; tick();
        a_t = 1;
        for (int cx = 0; cx < 4; cx++)
            for (int cy = 0; cy < 4; cy++)
                for (int dx = 0; dx < 4; dx++)
                    for (int dy = 0; dy < 4; dy++)
                        for (int sc = 0; sc < 2; sc++) begin
                            a_cx = 2'(cx); a_cy = 2'(cy); a_dx = 2'(dx); a_dy = 2'(dy);
                            a_sc = sc[0];
                            tick();
                            chk($sformatf("R1 R3 R4 R5 R6 4x4 (%0d,%0d)->(%0d,%0d) sc=%0d",
                                cx, cy, dx, dy, sc), a_port, ref_port(4, cx, cy, dx, dy, sc[0]));
                        end
        a_h = 0; tick();
        chk("R9 4x4 sweep end clear", a_port, 6'b0);

        b_h = 1; tick();
        b_t = 1;
        for (int cx = 0; cx < 5; cx++)
            for (int cy = 0; cy < 5; cy++)
                for (int dx = 0; dx < 5; dx++)
                    for (int dy = 0; dy < 5; dy++)
                        for (int sc = 0; sc < 2; sc++) begin
                            b_cx = 3'(cx); b_cy = 3'(cy); b_dx = 3'(dx); b_dy = 3'(dy);
                            b_sc = sc[0];
                            tick();
                            chk($sformatf("R1 R3 R4 R5 R6 5x5 (%0d,%0d)->(%0d,%0d) sc=%0d",
                                cx, cy, dx, dy, sc), b_port, ref_port(5, cx, cy, dx, dy, sc[0]));
                        end
        b_h = 0; tick();
        chk("R9 5x5 sweep end clear", b_port, 6'b0);

        // R11: reset while busy clears.
        b_h = 1; b_t = 0; tick();
        b_h = 0; rst = 1; tick();
        chk("R11 reset while busy", b_port, 6'b0);
        rst = 0;

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule